// File: doc/BRIEF.md
# Keyboard Matrix Scanner With Code Lookup

The block scans an 18-column by 8-row key matrix. It pulls one column line low at a time and releases all the others. After a settling delay it captures the 8 row lines, which have pull-ups, so a pressed key reads low. Each of the 144 key positions has a debounced pressed/released state. A key's state flips only after the new level has been seen on three consecutive full passes over the matrix.

When a key's debounced state flips, the block looks up a usage code in a 144-entry table. The table is loaded through a simple write port and laid out column by column. The block then offers a (code, make/break, class) event on a valid/ready output. The class tells normal keys, modifier keys and consumer hot keys apart. Table entries of zero mark empty matrix positions and never produce events.

While an event waits for the consumer, the scan freezes in place. Scanning moves from one column to the next only when a pacing tick is present.

Top module: `keymatrix_scanner`

## Requirements
- R1: At every cycle exactly one bit of `col_strobe_n_o` is 0, and all other bits are 1. Bit c corresponds to column c. Column 0 is the active column during and right after reset.
- R2: Columns are visited in ascending order 0,1,…,17, and the scan wraps from 17 to 0. The scan starts a column's settle phase only when `tick_i` is 1 while it is waiting. With `tick_i` held at 0, the active column does not change.
- R3: Rows are active low. Row r reads 0 while a pressed key joins row r to the column that is driven low. A key whose row reads 1 is treated as released.
- R4: Rows are captured no sooner than max(4, `settle_cfg_i`) clock cycles after the column starts its settle phase. The captured value must therefore not reflect the previous column's rows, as long as the lines settle within that count.
- R5: The code for column c, row r is the table entry at offset c*8+r. The entry is written by `tbl_we_i`/`tbl_addr_i`/`tbl_data_i`. The event code equals that entry.
- R6: A key whose table entry is 0x00 never produces an event, whether it is pressed or released.
- R7: `evt_class_o` is 1 (modifier) for codes 0xE0–0xE7. It is 2 (hot key) for any other code of 0xC0 or above, and 0 (normal) otherwise.
- R8: The debounced state starts as released. It flips only after three consecutive passes read the new level. A read that agrees with the current state restarts the count.
- R9: A release-to-press flip gives `evt_make_o`=1, and a press-to-release flip gives `evt_make_o`=0.
- R10: When several keys flip in the same pass, their events leave in ascending table-offset order.
- R11: While `evt_valid_o`=1 and `evt_ready_i`=0, the event payload and the column strobes hold their values. Every event is eventually delivered, so none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Scan pacing; lets the next column start |
| rows_i | input | 8 | Row lines, pulled up, low when pressed |
| settle_cfg_i | input | 8 | Settle count in clocks (values below 4 act as 4) |
| tbl_we_i | input | 1 | Code table write enable |
| tbl_addr_i | input | 8 | Code table write offset (column*8+row) |
| tbl_data_i | input | 8 | Code table write data |
| col_strobe_n_o | output | 18 | Column strobes, active low, one low at a time |
| evt_valid_o | output | 1 | Event available |
| evt_ready_i | input | 1 | Consumer accepts the event |
| evt_code_o | output | 8 | Usage code of the key |
| evt_make_o | output | 1 | 1 = press, 0 = release |
| evt_class_o | output | 2 | 0 normal, 1 modifier, 2 hot key |

## Verification
The matrix is driven by a behavioural model whose row lines lag the strobes by a chosen number of clocks. This separates correct settling from sampling of stale rows, for both the minimum count and a larger programmed count. Single presses held for two passes, for three passes, and with a one-pass break in between separate the debounce threshold from a counter that does not restart. A group of four keys spread over columns 0, 8 and 17 is pressed with the consumer stalled, which exposes ordering, class tagging and any dropped or altered event. An empty table position and a paused tick are shown to have no effect at the outputs.

// File: rtl/kms_pkg.sv
package kms_pkg;

  localparam int CODE_W     = 8;
  localparam int MIN_SETTLE = 4;

  typedef enum logic [1:0] {
    KEY_NORMAL   = 2'd0,
    KEY_MODIFIER = 2'd1,
    KEY_HOTKEY   = 2'd2
  } key_class_e;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_PROC   = 2'd2,
    ST_EMIT   = 2'd3
  } scan_st_e;

  // Modifier band sits inside the hot-key range, so it is tested first.
  function automatic key_class_e classify_code(input logic [CODE_W-1:0] code);
    if (code >= 8'hE0 && code <= 8'hE7) return KEY_MODIFIER;
    if (code >= 8'hC0) return KEY_HOTKEY;
    return KEY_NORMAL;
  endfunction

endpackage

// File: rtl/kms_strobe.sv
module kms_strobe #(
  parameter int NUM_COLS = 18,
  parameter int COL_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance_i,
  output logic [COL_W-1:0]    col_o,
  output logic [NUM_COLS-1:0] strobe_n_o
);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (advance_i) begin
      col_q <= (col_q == COL_W'(NUM_COLS - 1)) ? '0 : col_q + COL_W'(1);
    end
  end

  assign col_o = col_q;

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_strobe
    assign strobe_n_o[g] = (col_q != COL_W'(g));
  end

endmodule

// File: rtl/kms_code_table.sv
module kms_code_table #(
  parameter int DEPTH  = 144,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CODE_W-1:0] rdata_o
);

  logic [CODE_W-1:0] mem_q [DEPTH];
  logic              in_range_w;

  assign in_range_w = ({1'b0, waddr_i} < (ADDR_W + 1)'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && in_range_w) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/kms_debounce.sv
module kms_debounce #(
  parameter int NKEYS  = 144,
  parameter int IDX_W  = 8,
  parameter int PASSES = 3,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             raw_i,
  output logic             flip_o
);

  logic             stable_q [NKEYS];
  logic [CNT_W-1:0] cnt_q    [NKEYS];
  logic             differ_w;

  assign differ_w = (raw_i != stable_q[idx_i]);
  assign flip_o   = upd_i && differ_w && (cnt_q[idx_i] == CNT_W'(PASSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEYS; i++) begin
        stable_q[i] <= 1'b0;
        cnt_q[i]    <= '0;
      end
    end else if (upd_i) begin
      if (!differ_w) begin
        cnt_q[idx_i] <= '0;
      end else if (flip_o) begin
        stable_q[idx_i] <= raw_i;
        cnt_q[idx_i]    <= '0;
      end else begin
        cnt_q[idx_i] <= cnt_q[idx_i] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kms_pkg::*;
#(
  parameter int NUM_COLS   = 18,
  parameter int NUM_ROWS   = 8,
  parameter int SETTLE_W   = 8,
  parameter int DEB_PASSES = 3,
  localparam int NKEYS = NUM_COLS * NUM_ROWS,
  localparam int IDX_W = $clog2(NKEYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [NUM_ROWS-1:0] rows_i,
  input  logic [SETTLE_W-1:0] settle_cfg_i,
  input  logic                tbl_we_i,
  input  logic [IDX_W-1:0]    tbl_addr_i,
  input  logic [CODE_W-1:0]   tbl_data_i,
  output logic [NUM_COLS-1:0] col_strobe_n_o,
  output logic                evt_valid_o,
  input  logic                evt_ready_i,
  output logic [CODE_W-1:0]   evt_code_o,
  output logic                evt_make_o,
  output logic [1:0]          evt_class_o
);

  localparam int COL_W = $clog2(NUM_COLS);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int CNT_W = $clog2(DEB_PASSES + 1);

  function automatic logic [IDX_W-1:0] key_offset(input logic [COL_W-1:0] c,
                                                  input logic [ROW_W-1:0] r);
    return IDX_W'(c) * IDX_W'(NUM_ROWS) + IDX_W'(r);
  endfunction

  function automatic logic [SETTLE_W-1:0] settle_limit(input logic [SETTLE_W-1:0] cfg);
    return (cfg < SETTLE_W'(MIN_SETTLE)) ? SETTLE_W'(MIN_SETTLE) : cfg;
  endfunction

  scan_st_e            st_q;
  logic [ROW_W-1:0]    row_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [NUM_ROWS-1:0] rows_lat_q;
  logic [CODE_W-1:0]   evt_code_q;
  logic                evt_make_q;
  key_class_e          evt_class_q;

  logic [COL_W-1:0]    col_w;
  logic [IDX_W-1:0]    key_idx_w;
  logic [CODE_W-1:0]   code_w;
  logic                raw_w, flip_w, upd_w, emit_w;
  logic                row_last_w, row_latch_w, col_adv_w;

  assign key_idx_w   = key_offset(col_w, row_q);
  assign row_last_w  = (row_q == ROW_W'(NUM_ROWS - 1));
  assign row_latch_w = (st_q == ST_SETTLE) &&
                       ((settle_q + SETTLE_W'(1)) >= settle_limit(settle_cfg_i));
  assign raw_w       = ~rows_lat_q[row_q];
  assign upd_w       = (st_q == ST_PROC);
  assign emit_w      = upd_w && flip_w && (code_w != '0);
  assign col_adv_w   = row_last_w && ((upd_w && !emit_w) ||
                                      ((st_q == ST_EMIT) && evt_ready_i));

  kms_strobe #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance_i  (col_adv_w),
    .col_o      (col_w),
    .strobe_n_o (col_strobe_n_o)
  );

  kms_code_table #(.DEPTH(NKEYS), .ADDR_W(IDX_W), .CODE_W(CODE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (key_idx_w),
    .rdata_o (code_w)
  );

  kms_debounce #(.NKEYS(NKEYS), .IDX_W(IDX_W), .PASSES(DEB_PASSES), .CNT_W(CNT_W)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd_w),
    .idx_i  (key_idx_w),
    .raw_i  (raw_w),
    .flip_o (flip_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_WAIT;
      row_q       <= '0;
      settle_q    <= '0;
      rows_lat_q  <= '1;
      evt_code_q  <= '0;
      evt_make_q  <= 1'b0;
      evt_class_q <= KEY_NORMAL;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (tick_i) begin
            st_q     <= ST_SETTLE;
            settle_q <= '0;
          end
        end
        ST_SETTLE: begin
          if (row_latch_w) begin
            rows_lat_q <= rows_i;
            row_q      <= '0;
            st_q       <= ST_PROC;
          end else begin
            settle_q <= settle_q + SETTLE_W'(1);
          end
        end
        ST_PROC: begin
          if (emit_w) begin
            evt_code_q  <= code_w;
            evt_make_q  <= raw_w;
            evt_class_q <= classify_code(code_w);
            st_q        <= ST_EMIT;
          end else if (row_last_w) begin
            row_q <= '0;
            st_q  <= ST_WAIT;
          end else begin
            row_q <= row_q + ROW_W'(1);
          end
        end
        ST_EMIT: begin
          if (evt_ready_i) begin
            if (row_last_w) begin
              row_q <= '0;
              st_q  <= ST_WAIT;
            end else begin
              row_q <= row_q + ROW_W'(1);
              st_q  <= ST_PROC;
            end
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

  assign evt_valid_o = (st_q == ST_EMIT);
  assign evt_code_o  = evt_code_q;
  assign evt_make_o  = evt_make_q;
  assign evt_class_o = evt_class_q;

endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int NUM_COLS = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_COLS-1:0] col_strobe_n_o,
  input logic                evt_valid_o,
  input logic                evt_ready_i,
  input logic [7:0]          evt_code_o,
  input logic                evt_make_o,
  input logic [1:0]          evt_class_o,
  input logic                row_latch_w
);

  logic [NUM_COLS-1:0] prev_q;
  logic [3:0]          age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      age_q  <= 4'hF;
    end else begin
      prev_q <= col_strobe_n_o;
      if (col_strobe_n_o != prev_q) age_q <= 4'd1;
      else if (age_q != 4'hF)       age_q <= age_q + 4'd1;
    end
  end

  AST_ONE_COLUMN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_strobe_n_o) == 1); // R1

  AST_COLUMN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (col_strobe_n_o != $past(col_strobe_n_o)) |->
      (col_strobe_n_o == {$past(col_strobe_n_o[NUM_COLS-2:0]), $past(col_strobe_n_o[NUM_COLS-1])})); // R2

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch_w |-> (age_q >= 4'd4)); // R4

  AST_NO_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> (evt_code_o != 8'h00)); // R6

  AST_MODIFIER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o[7:3] == 5'b11100) |-> (evt_class_o == 2'd1)); // R7

  AST_STALL_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && !evt_ready_i) |=>
      (evt_valid_o && $stable(evt_code_o) && $stable(evt_make_o) && $stable(evt_class_o))); // R11

  AST_STALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && !evt_ready_i) |=> $stable(col_strobe_n_o)); // R11

endmodule

bind keymatrix_scanner kms_checker #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .col_strobe_n_o (col_strobe_n_o),
  .evt_valid_o    (evt_valid_o),
  .evt_ready_i    (evt_ready_i),
  .evt_code_o     (evt_code_o),
  .evt_make_o     (evt_make_o),
  .evt_class_o    (evt_class_o),
  .row_latch_w    (row_latch_w)
);

// File: tb/keymatrix_scanner_tb.sv
module keymatrix_scanner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 18;
  localparam int NR = 8;
  localparam int NK = NC * NR;

  logic          clk = 1'b0;
  logic          rst_n, tick, ready, we;
  logic [NR-1:0] rows;
  logic [7:0]    settle, waddr, wdata;
  logic [NC-1:0] strobe;
  logic          valid, make;
  logic [7:0]    code;
  logic [1:0]    cls;

  logic [NK-1:0] pressed;
  int            dly;
  logic [NC-1:0] pipe [12];

  int checks = 0, fails = 0, cyc = 0, seq_err = 0, wraps = 0;
  logic [NC-1:0] last_strobe;
  logic [7:0] ev_code [32];
  logic       ev_make [32];
  logic [1:0] ev_cls  [32];
  int         ev_n = 0;

  keymatrix_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rows_i(rows), .settle_cfg_i(settle),
    .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_data_i(wdata), .col_strobe_n_o(strobe),
    .evt_valid_o(valid), .evt_ready_i(ready), .evt_code_o(code), .evt_make_o(make),
    .evt_class_o(cls)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Matrix model: row lines follow the strobes after dly clocks.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= strobe;
      for (int i = 1; i < 12; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rows[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (!pipe[dly-1][c] && pressed[c*NR + r]) rows[r] = 1'b0;
    end
  end

  function automatic logic [7:0] exp_code(input int off);
    if (off == 10)  return 8'h00;
    if (off == 137) return 8'hE2;
    if (off == 143) return 8'hC7;
    return 8'(off + 1);
  endfunction

  function automatic logic [1:0] exp_class(input logic [7:0] c);
    if (c[7:3] == 5'b11100) return 2'd1;
    if (c[7:6] == 2'b11)    return 2'd2;
    return 2'd0;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ev(input int i, input int off, input bit mk, input string req);
    logic [7:0] c;
    c = exp_code(off);
    check(ev_code[i] == c, req, 32'(ev_code[i]), 32'(c));
    check(ev_make[i] == mk, req, 32'(ev_make[i]), 32'(mk));
    check(ev_cls[i] == exp_class(c), req, 32'(ev_cls[i]), 32'(exp_class(c)));
  endtask

  task automatic wait_mark(input int col);
    logic [NC-1:0] p, tgt;
    bit seen;
    tgt  = ~(NC'(1) << col);
    p    = strobe;
    seen = 1'b0;
    while (!seen) begin
      @(negedge clk);
      if (strobe != p && strobe == tgt) seen = 1'b1;
      p = strobe;
    end
  endtask

  task automatic marks(input int n, input int col);
    for (int i = 0; i < n; i++) wait_mark(col);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (ev_n < 32) begin
        ev_code[ev_n] = code;
        ev_make[ev_n] = make;
        ev_cls[ev_n]  = cls;
      end
      ev_n++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(~strobe) != 1) seq_err++;
      if (strobe != last_strobe) begin
        if (strobe != {last_strobe[NC-2:0], last_strobe[NC-1]}) seq_err++;
        if (strobe == ~NC'(1)) wraps++;
      end
    end
    last_strobe = strobe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      report();
    end
  end

  initial begin
    logic [NC-1:0] s0, s1;
    int stall_err;
    rst_n = 1'b0; tick = 1'b1; ready = 1'b1; we = 1'b0; waddr = '0; wdata = '0;
    settle = 8'd0; dly = 4; pressed = '0;
    repeat (5) @(negedge clk);
    check(strobe == ~NC'(1), "R1 reset column", 32'(strobe), 32'(~NC'(1)));
    check(valid == 1'b0, "R11 reset valid", 32'(valid), 0);
    rst_n = 1'b1;

    for (int off = 0; off < NK; off++) begin
      @(negedge clk);
      we = 1'b1; waddr = 8'(off); wdata = exp_code(off);
    end
    @(negedge clk); we = 1'b0;
    marks(2, 9);
    ev_n = 0;

    // R3 R5 R8 R9: single key, column 4 row 5
    wait_mark(9); pressed[37] = 1'b1;
    marks(2, 9);
    check(ev_n == 0, "R8 two passes", ev_n, 0);
    wait_mark(9);
    check(ev_n == 1, "R8 third pass", ev_n, 1);
    check_ev(0, 37, 1'b1, "R5 R9 make");
    pressed[37] = 1'b0;
    marks(3, 9);
    check(ev_n == 2, "R9 break count", ev_n, 2);
    check_ev(1, 37, 1'b0, "R9 break");

    // R8: interrupted press restarts the count
    ev_n = 0;
    wait_mark(9); pressed[20] = 1'b1;
    marks(2, 9); pressed[20] = 1'b0;
    wait_mark(9); pressed[20] = 1'b1;
    marks(2, 9);
    check(ev_n == 0, "R8 restart", ev_n, 0);
    wait_mark(9);
    check(ev_n == 1, "R8 after restart", ev_n, 1);
    check_ev(0, 20, 1'b1, "R8 make");
    pressed[20] = 1'b0;
    marks(3, 9);
    check(ev_n == 2, "R8 release", ev_n, 2);

    // R6: empty position
    ev_n = 0;
    wait_mark(9); pressed[10] = 1'b1;
    marks(4, 9);
    check(ev_n == 0, "R6 press", ev_n, 0);
    pressed[10] = 1'b0;
    marks(4, 9);
    check(ev_n == 0, "R6 release", ev_n, 0);

    // R7 R10 R11: four keys, consumer stalled
    ev_n = 0; ready = 1'b0;
    wait_mark(0);
    pressed[143] = 1'b1; pressed[3] = 1'b1; pressed[137] = 1'b1; pressed[70] = 1'b1;
    while (!valid) @(negedge clk);
    s0 = strobe; stall_err = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!valid || strobe != s0 || code != exp_code(3)) stall_err++;
    end
    check(stall_err == 0, "R11 stall hold", stall_err, 0);
    ready = 1'b1;
    marks(2, 0);
    check(ev_n == 4, "R11 no drop", ev_n, 4);
    check_ev(0, 3,   1'b1, "R10 order 0");
    check_ev(1, 70,  1'b1, "R10 order 1");
    check_ev(2, 137, 1'b1, "R7 modifier");
    check_ev(3, 143, 1'b1, "R7 hotkey");

    ev_n = 0;
    wait_mark(0); pressed = '0;
    marks(3, 0);
    check(ev_n == 4, "R10 break count", ev_n, 4);
    check_ev(0, 3,   1'b0, "R10 break 0");
    check_ev(3, 143, 1'b0, "R10 break 3");

    // R4: larger programmed settle with slower lines
    settle = 8'd10; dly = 10; ev_n = 0;
    marks(2, 0);
    wait_mark(0); pressed[100] = 1'b1;
    marks(3, 0);
    check(ev_n == 1, "R4 slow settle count", ev_n, 1);
    check_ev(0, 100, 1'b1, "R4 slow settle");
    pressed[100] = 1'b0;
    marks(3, 0);
    check(ev_n == 2, "R4 slow release", ev_n, 2);
    settle = 8'd0; dly = 4;

    // R2: tick gating
    @(negedge clk); tick = 1'b0;
    repeat (60) @(negedge clk);
    s0 = strobe;
    repeat (60) @(negedge clk);
    check(strobe == s0, "R2 paused", 32'(strobe), 32'(s0));
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    repeat (40) @(negedge clk);
    s1 = {s0[NC-2:0], s0[NC-1]};
    check(strobe == s1, "R2 one step", 32'(strobe), 32'(s1));
    tick = 1'b1;
    repeat (20) @(negedge clk);

    check(seq_err == 0, "R1 R2 sequence", seq_err, 0);
    check(wraps > 0, "R2 wrap", wraps, 1);
    report();
  end

endmodule